// File: doc/BRIEF.md
# ULPI Link-Side Receive Decoder

This block sits on the link side of a ULPI bus and turns the traffic the PHY drives toward the link into a clean receive byte stream. It samples the direction, next and 8-bit data lines on every ULPI clock edge. It masks the turnaround cycle that follows every change of direction. It sorts each PHY-driven cycle into one of two kinds: a status byte (RXD CMD) or a received packet byte.

Downstream logic sees one-cycle start and end strobes, a data-valid strobe with its byte, and an error flag that holds for the rest of a packet. It also sees the decoded line state, VBUS state, ID level and receive activity. A transmit-permission output tells the link's transmit side when it may start driving the bus again. That output accounts for the turnaround cycle. At full speed it also enforces a programmable quiet gap after the end of a packet.

Top module: `ulpi_rx_decoder`

## Requirements
- R1: After reset every strobe is low, rx_active and rx_err are low, the status outputs are zero, and tx_ok is high.
- R2: In the first cycle after any change of ulpi_dir, the bus byte is ignored: no valid strobe is raised and no status field changes.
- R3: When ulpi_dir rises with ulpi_nxt high in the same cycle, rx_active goes high and rx_sop pulses for one cycle, and no byte is delivered for that cycle.
- R4: When ulpi_dir stays high and ulpi_nxt is low, the bus byte is a status byte. Its bits 1:0 go to line_state, bits 3:2 go to vbus_state, and bit 6 goes to id_state.
- R5: When ulpi_dir stays high and ulpi_nxt is high inside a packet, rx_valid pulses and rx_byte carries the bus byte. If ulpi_nxt is high while no packet is active, the byte is dropped.
- R6: A status byte whose event field (bits 5:4) is 00, arriving during a packet, clears rx_active and pulses rx_eop.
- R7: If ulpi_dir falls during a packet, rx_active clears and rx_eop pulses.
- R8: An event field of 11 during a packet sets rx_err. rx_err stays set until the next packet starts.
- R9: A status byte with event field 01 or 11 while no packet is active starts a packet: rx_active goes high and rx_sop pulses.
- R10: tx_ok is low in the cycle after a sample with ulpi_dir high, in the turnaround cycle after ulpi_dir falls, and while rx_active is high.
- R11: After an end of packet with fs_mode high, tx_ok stays low for FS_GAP_CYC further cycles. With fs_mode low, no extra gap is added.
- R12: Every output reflects the sample taken at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_mode | input | 1 | High when the bus runs at full speed |
| ulpi_dir | input | 1 | Bus direction, high when the PHY drives |
| ulpi_nxt | input | 1 | PHY next/throttle line |
| ulpi_data | input | 8 | ULPI data bus as seen by the link |
| rx_byte | output | 8 | Last received packet byte |
| rx_valid | output | 1 | Pulses when rx_byte holds a new byte |
| rx_sop | output | 1 | Start-of-packet strobe |
| rx_eop | output | 1 | End-of-packet strobe |
| rx_err | output | 1 | Receive error seen in the current or last packet |
| rx_active | output | 1 | Packet reception in progress |
| line_state | output | 2 | Line state from the last status byte |
| vbus_state | output | 2 | VBUS state from the last status byte |
| id_state | output | 1 | ID level from the last status byte |
| tx_ok | output | 1 | Link may begin driving the bus |

## Verification
The bench puts garbage on the bus in turnaround cycles. A design that failed to mask them would update line_state or emit a spurious byte. It starts packets both ways: direction and next rising together, and a status byte with event 01. A decoder that knew only one way would miss a start strobe or drop a whole packet's bytes. Packets end both by an event 00 status byte and by the direction line dropping, and an error event is inserted mid-packet. A decoder that got these wrong would leave rx_active stuck or clear the error flag too early. Finally, the number of cycles until tx_ok returns is counted after full-speed and high-speed packet ends. An off-by-one in the gap counter, or a missing turnaround hold, shows up directly in that count.

// File: rtl/ulpi_rx_pkg.sv
package ulpi_rx_pkg;

  localparam int unsigned ULPI_DW = 8;

  // Receive event field of a status byte
  typedef enum logic [1:0] {
    EV_IDLE   = 2'b00,
    EV_ACTIVE = 2'b01,
    EV_DISC   = 2'b10,
    EV_ERROR  = 2'b11
  } rx_ev_e;

  // Status byte layout, MSB first
  typedef struct packed {
    logic       spare;
    logic       id;
    logic [1:0] ev;
    logic [1:0] vbus;
    logic [1:0] ls;
  } rxcmd_t;

endpackage

// File: rtl/ulpi_bus_tracker.sv
// Tracks bus ownership and classifies each sampled cycle (R2).
module ulpi_bus_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic nxt,
  input  logic pkt_active,
  output logic dir_r,
  output logic turn_r,
  output logic start_c,
  output logic cmd_c,
  output logic data_c,
  output logic drop_c
);

  logic dir_d, turn_d;

  always_comb begin
    dir_d   = dir;
    turn_d  = dir ^ dir_r;
    start_c = dir & ~dir_r & nxt;
    cmd_c   = dir & dir_r & ~nxt;
    data_c  = dir & dir_r & nxt & pkt_active;
    drop_c  = ~dir & dir_r & pkt_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_r  <= 1'b0;
      turn_r <= 1'b0;
    end else begin
      dir_r  <= dir_d;
      turn_r <= turn_d;
    end
  end

endmodule

// File: rtl/ulpi_rxcmd_decode.sv
// Holds the status fields of the last status byte (R4).
module ulpi_rxcmd_decode
  import ulpi_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_c,
  input  logic [ULPI_DW-1:0] data,
  output rx_ev_e             ev_c,
  output logic [1:0]         ls_q,
  output logic [1:0]         vbus_q,
  output logic               id_q
);

  rxcmd_t     cmd;
  logic [1:0] ls_d, vbus_d;
  logic       id_d;

  always_comb begin
    cmd    = rxcmd_t'(data);
    ev_c   = rx_ev_e'(cmd.ev);
    ls_d   = cmd_c ? cmd.ls   : ls_q;
    vbus_d = cmd_c ? cmd.vbus : vbus_q;
    id_d   = cmd_c ? cmd.id   : id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q   <= '0;
      vbus_q <= '0;
      id_q   <= 1'b0;
    end else begin
      ls_q   <= ls_d;
      vbus_q <= vbus_d;
      id_q   <= id_d;
    end
  end

endmodule

// File: rtl/ulpi_fs_gap_timer.sv
// Quiet-gap counter after a full-speed end of packet (R11).
module ulpi_fs_gap_timer #(
  parameter int unsigned GAP_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  output logic expired
);

  localparam int unsigned CW = (GAP_CYC > 0) ? $clog2(GAP_CYC + 1) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)
      cnt_d = LOAD_VAL;
    else if (clr)
      cnt_d = '0;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
    expired = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ulpi_rx_decoder.sv
module ulpi_rx_decoder
  import ulpi_rx_pkg::*;
#(
  parameter int unsigned FS_GAP_CYC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_mode,
  input  logic               ulpi_dir,
  input  logic               ulpi_nxt,
  input  logic [ULPI_DW-1:0] ulpi_data,
  output logic [ULPI_DW-1:0] rx_byte,
  output logic               rx_valid,
  output logic               rx_sop,
  output logic               rx_eop,
  output logic               rx_err,
  output logic               rx_active,
  output logic [1:0]         line_state,
  output logic [1:0]         vbus_state,
  output logic               id_state,
  output logic               tx_ok
);

  logic   dir_r, turn_r, start_c, cmd_c, data_c, drop_c;
  rx_ev_e ev_c;
  logic   gap_done;

  logic               act_q, act_d;
  logic               err_q, err_d;
  logic               sop_q, sop_d;
  logic               eop_q, eop_d;
  logic               val_q, val_d;
  logic [ULPI_DW-1:0] byte_q;

  ulpi_bus_tracker u_bus (
    .clk(clk), .rst_n(rst_n), .dir(ulpi_dir), .nxt(ulpi_nxt),
    .pkt_active(act_q), .dir_r(dir_r), .turn_r(turn_r),
    .start_c(start_c), .cmd_c(cmd_c), .data_c(data_c), .drop_c(drop_c)
  );

  ulpi_rxcmd_decode u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_c(cmd_c), .data(ulpi_data),
    .ev_c(ev_c), .ls_q(line_state), .vbus_q(vbus_state), .id_q(id_state)
  );

  // Packet start/end decisions (R3, R6, R7, R8, R9)
  always_comb begin
    sop_d = (start_c & ~act_q) | (cmd_c & ~act_q & ev_c[0]);
    eop_d = (cmd_c & act_q & (ev_c == EV_IDLE)) | drop_c;
    val_d = data_c;
    if (sop_d)      act_d = 1'b1;
    else if (eop_d) act_d = 1'b0;
    else            act_d = act_q;
    if (sop_d)
      err_d = cmd_c & (ev_c == EV_ERROR);
    else if (cmd_c & act_q & (ev_c == EV_ERROR))
      err_d = 1'b1;
    else
      err_d = err_q;
  end

  ulpi_fs_gap_timer #(.GAP_CYC(FS_GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(eop_d & fs_mode), .clr(eop_d & ~fs_mode),
    .expired(gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      sop_q <= 1'b0;
      eop_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
      sop_q <= sop_d;
      eop_q <= eop_d;
      val_q <= val_d;
    end
  end

  // Byte register, loaded only on a packet byte (R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (data_c) byte_q <= ulpi_data;
  end

  always_comb begin
    rx_byte   = byte_q;
    rx_valid  = val_q;
    rx_sop    = sop_q;
    rx_eop    = eop_q;
    rx_err    = err_q;
    rx_active = act_q;
    tx_ok     = ~dir_r & ~turn_r & ~act_q & gap_done; // R10, R11
  end

endmodule

// File: rtl/ulpi_rx_decoder_chk.sv
module ulpi_rx_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs_mode,
  input logic       ulpi_dir,
  input logic       ulpi_nxt,
  input logic [7:0] ulpi_data,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       rx_sop,
  input logic       rx_eop,
  input logic       rx_err,
  input logic       rx_active,
  input logic [1:0] line_state,
  input logic [1:0] vbus_state,
  input logic       id_state,
  input logic       tx_ok
);

  p_turn_no_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_dir != $past(ulpi_dir)) |=> !rx_valid);

  p_turn_status_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_dir && !$past(ulpi_dir)) |=> $stable(line_state));

  p_start_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_dir && !$past(ulpi_dir) && ulpi_nxt && !rx_active) |=> (rx_sop && rx_active));

  p_byte_in_packet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);

  p_eop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |-> !rx_active);

  p_dir_drop_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ulpi_dir && $past(ulpi_dir) && rx_active) |=> rx_eop);

  p_strobes_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_sop && rx_eop));

  p_phy_owns_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_dir |=> !tx_ok);

  p_active_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !tx_ok);

endmodule

bind ulpi_rx_decoder ulpi_rx_decoder_chk u_chk (.*);

// File: tb/ulpi_rx_decoder_bench.sv
`timescale 1ns/1ps
module ulpi_rx_decoder_bench;

  localparam int GAP = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, fs_mode, ulpi_dir, ulpi_nxt;
  logic [7:0] ulpi_data, rx_byte;
  logic       rx_valid, rx_sop, rx_eop, rx_err, rx_active, id_state, tx_ok;
  logic [1:0] line_state, vbus_state;

  ulpi_rx_decoder #(.FS_GAP_CYC(GAP)) u_ulpi_rx_decoder (
    .clk(clk), .rst_n(rst_n), .fs_mode(fs_mode), .ulpi_dir(ulpi_dir),
    .ulpi_nxt(ulpi_nxt), .ulpi_data(ulpi_data), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err),
    .rx_active(rx_active), .line_state(line_state), .vbus_state(vbus_state),
    .id_state(id_state), .tx_ok(tx_ok)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Expected-state model built from the requirements
  logic       m_dq, m_turn, m_act, m_err, m_sop, m_eop, m_val, m_id;
  logic [7:0] m_byte;
  logic [1:0] m_ls, m_vb;
  int         m_gap;

  function automatic logic exp_txok();
    return !m_dq && !m_turn && !m_act && (m_gap == 0);
  endfunction

  function automatic logic [7:0] mk_cmd(logic [1:0] ev, logic [1:0] ls,
                                        logic [1:0] vb, logic id);
    return {1'b0, id, ev, vb, ls};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_dq = 0; m_turn = 0; m_act = 0; m_err = 0; m_sop = 0; m_eop = 0;
    m_val = 0; m_byte = 0; m_ls = 0; m_vb = 0; m_id = 0; m_gap = 0;
  endtask

  task automatic model_step(logic d, logic n, logic [7:0] b, logic fs);
    logic start, cmd, dat, drop, sop, eop;
    logic [1:0] ev;
    ev    = b[5:4];
    start = d && !m_dq && n;
    cmd   = d && m_dq && !n;
    dat   = d && m_dq && n && m_act;
    drop  = !d && m_dq && m_act;
    sop   = (start && !m_act) || (cmd && !m_act && ev[0]);
    eop   = (cmd && m_act && ev == 2'b00) || drop;
    if (sop)                                  m_err = cmd && (ev == 2'b11);
    else if (cmd && m_act && ev == 2'b11)     m_err = 1;
    if (cmd) begin m_ls = b[1:0]; m_vb = b[3:2]; m_id = b[6]; end
    if (eop)             m_gap = fs ? GAP : 0;
    else if (m_gap > 0)  m_gap--;
    if (sop) m_act = 1; else if (eop) m_act = 0;
    if (dat) m_byte = b;
    m_sop = sop; m_eop = eop; m_val = dat;
    m_turn = d ^ m_dq;
    m_dq = d;
  endtask

  task automatic compare_all();
    chk("R3 rx_sop", {7'd0, rx_sop}, {7'd0, m_sop});
    chk("R6 R7 rx_eop", {7'd0, rx_eop}, {7'd0, m_eop});
    chk("R5 rx_valid", {7'd0, rx_valid}, {7'd0, m_val});
    if (m_val) chk("R5 rx_byte", rx_byte, m_byte);
    chk("R9 rx_active", {7'd0, rx_active}, {7'd0, m_act});
    chk("R8 rx_err", {7'd0, rx_err}, {7'd0, m_err});
    chk("R4 status", {1'b0, id_state, vbus_state, line_state, 2'b0},
                     {1'b0, m_id, m_vb, m_ls, 2'b0});
    chk("R10 R11 tx_ok", {7'd0, tx_ok}, {7'd0, exp_txok()});
  endtask

  // One bus cycle: drive at falling edge, sample just after rising edge (R12)
  task automatic cyc(logic d, logic n, logic [7:0] b);
    @(negedge clk);
    ulpi_dir = d; ulpi_nxt = n; ulpi_data = b;
    @(posedge clk);
    model_step(d, n, b, fs_mode);
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int k;
    void'($urandom(32'd2024));
    rst_n = 0; fs_mode = 0; ulpi_dir = 0; ulpi_nxt = 0; ulpi_data = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #0.5;
    // R1: reset state
    chk("R1 strobes", {4'd0, rx_sop, rx_eop, rx_valid, rx_err}, 8'd0);
    chk("R1 active", {7'd0, rx_active}, 8'd0);
    chk("R1 status", {3'd0, id_state, vbus_state, line_state}, 8'd0);
    chk("R1 tx_ok", {7'd0, tx_ok}, 8'd1);

    // R2: turnaround byte ignored
    cyc(1, 0, 8'h5F);
    chk("R2 line_state held", {6'd0, line_state}, 8'd0);
    chk("R10 tx_ok low with dir", {7'd0, tx_ok}, 8'd0);
    // R4: status byte fields
    cyc(1, 0, mk_cmd(2'b00, 2'b10, 2'b11, 1'b1));
    chk("R4 fields", {3'd0, id_state, vbus_state, line_state}, 8'b0001_1110);
    // R5: nxt high outside a packet drops the byte
    cyc(1, 1, 8'hAA);
    chk("R5 no byte outside packet", {7'd0, rx_valid}, 8'd0);
    cyc(0, 0, 8'h00);
    chk("R10 turnaround hold", {7'd0, tx_ok}, 8'd0);
    cyc(0, 0, 8'h00);
    chk("R10 tx_ok after turnaround", {7'd0, tx_ok}, 8'd1);

    // High-speed packet: start with dir+nxt, error event, end by dir drop
    fs_mode = 0;
    cyc(1, 1, 8'hFF);
    chk("R3 sop", {6'd0, rx_sop, rx_active}, 8'd3);
    chk("R3 no byte on start", {7'd0, rx_valid}, 8'd0);
    cyc(1, 1, 8'h11);
    chk("R5 byte", rx_byte, 8'h11);
    cyc(1, 0, mk_cmd(2'b01, 2'b01, 2'b11, 1'b0));
    cyc(1, 0, mk_cmd(2'b11, 2'b01, 2'b11, 1'b0));
    chk("R8 err set", {7'd0, rx_err}, 8'd1);
    cyc(1, 1, 8'h22);
    chk("R5 byte after cmd", rx_byte, 8'h22);
    cyc(0, 0, 8'h00);
    chk("R7 eop by dir drop", {6'd0, rx_eop, rx_active}, 8'd2);
    chk("R8 err held after end", {7'd0, rx_err}, 8'd1);
    cyc(0, 0, 8'h00);
    chk("R11 no gap in high speed", {7'd0, tx_ok}, 8'd1);

    // Full-speed packet: start by event 01, end by event 00
    fs_mode = 1;
    cyc(1, 0, 8'h3C);
    chk("R2 turnaround no start", {7'd0, rx_active}, 8'd0);
    cyc(1, 0, mk_cmd(2'b01, 2'b00, 2'b11, 1'b1));
    chk("R9 start by status", {6'd0, rx_sop, rx_active}, 8'd3);
    chk("R8 err cleared at start", {7'd0, rx_err}, 8'd0);
    cyc(1, 1, 8'h5A);
    cyc(1, 0, mk_cmd(2'b01, 2'b10, 2'b11, 1'b1));
    cyc(1, 1, 8'hA5);
    cyc(1, 0, mk_cmd(2'b00, 2'b01, 2'b11, 1'b1));
    chk("R6 eop by status", {6'd0, rx_eop, rx_active}, 8'd2);
    k = 0;
    while (!tx_ok && k < 50) begin cyc(0, 0, 8'h00); k++; end
    chk("R11 fs gap length", 8'(k), 8'(GAP));

    // Constrained random packets
    for (int p = 0; p < 400; p++) begin
      fs_mode = $urandom % 2;
      repeat (1 + $urandom % 4) cyc(0, $urandom % 2, 8'($urandom));
      if ($urandom % 2) cyc(1, 1, 8'($urandom));
      else begin
        cyc(1, 0, 8'($urandom));
        cyc(1, 0, mk_cmd(2'b01, 2'($urandom), 2'($urandom), 1'($urandom)));
      end
      for (int j = 0; j < int'(1 + $urandom % 12); j++) begin
        int r = $urandom % 20;
        if (r < 14)      cyc(1, 1, 8'($urandom));
        else if (r < 19) cyc(1, 0, mk_cmd(2'b01, 2'($urandom), 2'($urandom), 1'($urandom)));
        else             cyc(1, 0, mk_cmd(2'b11, 2'($urandom), 2'($urandom), 1'($urandom)));
      end
      if ($urandom % 2) cyc(1, 0, mk_cmd(2'b00, 2'($urandom), 2'($urandom), 1'($urandom)));
      if ($urandom % 8 == 0)
        repeat (4) cyc($urandom % 2, $urandom % 2, 8'($urandom));
      cyc(0, 0, 8'h00);
    end
    repeat (GAP + 2) cyc(0, 0, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule